// File: doc/BRIEF.md
# Proactive Epoch Flush Sequencer

This controller sits beside a core's private cache and makes completed epochs durable strictly in the order they began on that core. Each epoch that starts is recorded in a small in-order queue of epoch identifiers. The youngest entry is the epoch still executing. Once an entry is closed, the sequencer starts persisting it at once, without waiting for any conflict to ask for it.

The oldest closed entry is worked in a fixed sequence. First the cross-core dependency tables are asked whether the epoch still waits on an unpersisted source epoch. Next the epoch's dirty lines are written back. Then a flush naming the epoch is sent to every last-level cache partition, and an acknowledgement is collected from each one. A confirming broadcast tells the partitions that lines from later epochs may now leave. Finally a one-cycle persisted pulse lets the dependency tables wake up dependents on other cores, and the entry is retired.

A partition that must evict a line can ask for an early flush. This closes the executing epoch so that it becomes eligible for flushing.

Top module: `epoch_flush_seq`

## Requirements
- R1: After reset the queue reports empty and not full, and `dep_query_valid_o`, `wb_req_o`, `part_flush_o`, `final_ack_o` and `persisted_o` are all low.
- R2: Epochs are persisted in the order their `ep_start_i` pulses arrived. The identifier on `wb_id_o`, `flush_id_o` and `persisted_id_o` is that of the oldest queue entry.
- R3: An epoch that is still executing (not yet closed) is never queried, written back or flushed.
- R4: While `dep_blocked_i` is high during a query, no writeback is requested and the query stays up with the same identifier. The sequence resumes on the cycle after it drops.
- R5: `wb_req_o` stays high with a stable identifier until `wb_done_i` is seen. No partition flush is sent before that.
- R6: In the cycle after `wb_done_i`, `part_flush_o` is all ones for exactly one cycle, with the epoch on `flush_id_o`.
- R7: `final_ack_o` rises for exactly one cycle, and only after every partition has acknowledged at least once since the flush. Acknowledgements may arrive in any order, together, or repeated.
- R8: `persisted_o` pulses for one cycle, in the cycle after `final_ack_o`, with the same identifier. The entry is then removed.
- R9: A closed, unblocked oldest entry is queried in the second cycle after `ep_end_i`, with no other request needed.
- R10: Any bit of `early_req_i` closes the youngest executing epoch, which is then persisted like an epoch closed by `ep_end_i`.
- R11: When the queue holds DEPTH entries, `fifo_full_o` is high and further `ep_start_i` pulses are dropped. Only the stored epochs are ever persisted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ep_start_i | input | 1 | A new epoch begins on the core |
| ep_start_id_i | input | ID_W | Global identifier of the starting epoch |
| ep_end_i | input | 1 | Closes the youngest executing epoch |
| early_req_i | input | NPART | Per-partition early flush request |
| fifo_full_o | output | 1 | Epoch queue full |
| fifo_empty_o | output | 1 | Epoch queue empty |
| dep_query_valid_o | output | 1 | Dependency query for the oldest epoch |
| dep_query_id_o | output | ID_W | Queried epoch identifier |
| dep_blocked_i | input | 1 | Queried epoch still waits on a source epoch |
| wb_req_o | output | 1 | Dirty-line writeback request |
| wb_id_o | output | ID_W | Epoch to write back |
| wb_done_i | input | 1 | Writeback of the requested epoch finished |
| part_flush_o | output | NPART | Flush message to each partition |
| flush_id_o | output | ID_W | Epoch named by flush and confirming broadcast |
| part_ack_i | input | NPART | Acknowledgement from each partition |
| final_ack_o | output | 1 | Confirming broadcast to all partitions |
| persisted_o | output | 1 | One-cycle pulse: epoch is durable |
| persisted_id_o | output | ID_W | Identifier of the persisted epoch |

## Verification
On every cycle the assertions check the protocol at the edges. The writeback request holds until it is done. A flush pulse only follows a finished writeback and reaches all partitions. The confirming broadcast is single and comes only after a complete set of acknowledgements, which an independent mask in the checker tracks. The persisted pulse follows that broadcast with the same identifier, and a blocked query never leads straight into a writeback. Some behaviours only the directed scenarios can show: the start order of persisted epochs, that an executing epoch is left alone, the proactive start two cycles after closing, closing by an early partition request, and dropping of starts into a full queue.

// File: rtl/efs_pkg.sv
package efs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WB,
        ST_ACKS,
        ST_FINAL,
        ST_POP
    } seq_state_e;

endpackage

// File: rtl/efs_epoch_queue.sv
module efs_epoch_queue #(
    parameter int DEPTH = 4,
    parameter int ID_W  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_i,
    input  logic [ID_W-1:0] push_id_i,
    input  logic            close_i,
    input  logic            pop_i,
    output logic [ID_W-1:0] head_id_o,
    output logic            head_ended_o,
    output logic            empty_o,
    output logic            full_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][ID_W-1:0] ids;
        logic [DEPTH-1:0]           ended;
        logic [PTR_W-1:0]           wr;
        logic [PTR_W-1:0]           rd;
        logic [CNT_W-1:0]           cnt;
    } queue_t;

    queue_t q_q, q_d;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic [PTR_W-1:0] youngest;
    logic             do_push, do_pop;

    always_comb begin
        q_d      = q_q;
        youngest = (q_q.wr == '0) ? PTR_W'(DEPTH - 1) : q_q.wr - 1'b1;
        do_push  = push_i && (q_q.cnt != CNT_W'(DEPTH));
        do_pop   = pop_i && (q_q.cnt != '0);
        if (close_i && (q_q.cnt != '0)) begin
            q_d.ended[youngest] = 1'b1;
        end
        if (do_push) begin
            q_d.ids[q_q.wr]   = push_id_i;
            q_d.ended[q_q.wr] = 1'b0;
            q_d.wr            = ptr_inc(q_q.wr);
        end
        if (do_pop) begin
            q_d.rd = ptr_inc(q_q.rd);
        end
        case ({do_push, do_pop})
            2'b10:   q_d.cnt = q_q.cnt + 1'b1;
            2'b01:   q_d.cnt = q_q.cnt - 1'b1;
            default: q_d.cnt = q_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head_id_o    = q_q.ids[q_q.rd];
    assign head_ended_o = (q_q.cnt != '0) && q_q.ended[q_q.rd];
    assign empty_o      = (q_q.cnt == '0);
    assign full_o       = (q_q.cnt == CNT_W'(DEPTH));

endmodule

// File: rtl/efs_ack_barrier.sv
module efs_ack_barrier #(
    parameter int NPART = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             collect_i,
    input  logic [NPART-1:0] ack_i,
    output logic             all_o
);
    typedef struct packed {
        logic [NPART-1:0] got;
    } barrier_t;

    barrier_t b_q, b_d;

    always_comb begin
        b_d = b_q;
        if (clear_i)        b_d.got = '0;
        else if (collect_i) b_d.got = b_q.got | ack_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign all_o = collect_i && (&(b_q.got | ack_i));

endmodule

// File: rtl/epoch_flush_seq.sv
module epoch_flush_seq #(
    parameter int NPART = 4,
    parameter int DEPTH = 4,
    parameter int ID_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ep_start_i,
    input  logic [ID_W-1:0]  ep_start_id_i,
    input  logic             ep_end_i,
    input  logic [NPART-1:0] early_req_i,
    output logic             fifo_full_o,
    output logic             fifo_empty_o,
    output logic             dep_query_valid_o,
    output logic [ID_W-1:0]  dep_query_id_o,
    input  logic             dep_blocked_i,
    output logic             wb_req_o,
    output logic [ID_W-1:0]  wb_id_o,
    input  logic             wb_done_i,
    output logic [NPART-1:0] part_flush_o,
    output logic [ID_W-1:0]  flush_id_o,
    input  logic [NPART-1:0] part_ack_i,
    output logic             final_ack_o,
    output logic             persisted_o,
    output logic [ID_W-1:0]  persisted_id_o
);
    import efs_pkg::*;

    typedef struct packed {
        seq_state_e st;
        logic       flush_pend;
    } seq_t;

    seq_t s_q, s_d;

    logic [ID_W-1:0] head_id;
    logic            head_ended;
    logic            acks_all;
    logic            ack_clear;
    logic            do_pop;

    efs_epoch_queue #(.DEPTH(DEPTH), .ID_W(ID_W)) u_queue (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (ep_start_i),
        .push_id_i    (ep_start_id_i),
        .close_i      (ep_end_i || (|early_req_i)),
        .pop_i        (do_pop),
        .head_id_o    (head_id),
        .head_ended_o (head_ended),
        .empty_o      (fifo_empty_o),
        .full_o       (fifo_full_o)
    );

    efs_ack_barrier #(.NPART(NPART)) u_barrier (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (ack_clear),
        .collect_i (s_q.st == ST_ACKS),
        .ack_i     (part_ack_i),
        .all_o     (acks_all)
    );

    always_comb begin
        s_d            = s_q;
        s_d.flush_pend = 1'b0;
        ack_clear      = 1'b0;
        do_pop         = 1'b0;
        case (s_q.st)
            ST_IDLE:  if (head_ended) s_d.st = ST_CHECK;
            ST_CHECK: if (!dep_blocked_i) s_d.st = ST_WB;
            ST_WB: begin
                if (wb_done_i) begin
                    s_d.st         = ST_ACKS;
                    s_d.flush_pend = 1'b1;
                    ack_clear      = 1'b1;
                end
            end
            ST_ACKS:  if (acks_all) s_d.st = ST_FINAL;
            ST_FINAL: s_d.st = ST_POP;
            ST_POP: begin
                do_pop = 1'b1;
                s_d.st = ST_IDLE;
            end
            default:  s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, flush_pend: 1'b0};
        else        s_q <= s_d;
    end

    assign dep_query_valid_o = (s_q.st == ST_CHECK);
    assign dep_query_id_o    = head_id;
    assign wb_req_o          = (s_q.st == ST_WB);
    assign wb_id_o           = head_id;
    assign part_flush_o      = ((s_q.st == ST_ACKS) && s_q.flush_pend) ? '1 : '0;
    assign flush_id_o        = head_id;
    assign final_ack_o       = (s_q.st == ST_FINAL);
    assign persisted_o       = (s_q.st == ST_POP);
    assign persisted_id_o    = head_id;

endmodule

// File: rtl/efs_chk.sv
module efs_chk #(
    parameter int NPART = 4,
    parameter int ID_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_full_o,
    input logic             fifo_empty_o,
    input logic             dep_query_valid_o,
    input logic             dep_blocked_i,
    input logic             wb_req_o,
    input logic [ID_W-1:0]  wb_id_o,
    input logic             wb_done_i,
    input logic [NPART-1:0] part_flush_o,
    input logic [ID_W-1:0]  flush_id_o,
    input logic [NPART-1:0] part_ack_i,
    input logic             final_ack_o,
    input logic             persisted_o,
    input logic [ID_W-1:0]  persisted_id_o
);
    logic [NPART-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             seen_q <= '0;
        else if (|part_flush_o) seen_q <= part_ack_i;
        else                    seen_q <= seen_q | part_ack_i;
    end

    // R4
    blocked_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dep_query_valid_o && dep_blocked_i) |=> !wb_req_o);

    // R5
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req_o && !wb_done_i) |=> (wb_req_o && $stable(wb_id_o)));

    // R6
    flush_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|part_flush_o) |-> ($past(wb_req_o && wb_done_i) && (&part_flush_o)));

    // R7
    final_all_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        final_ack_o |-> (&seen_q));

    // R7
    final_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        final_ack_o |=> !final_ack_o);

    // R8
    persist_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        persisted_o |-> ($past(final_ack_o) && (persisted_id_o == $past(flush_id_o))));

    // R11
    full_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full_o |-> !fifo_empty_o);

endmodule

bind epoch_flush_seq efs_chk #(.NPART(NPART), .ID_W(ID_W)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .fifo_full_o       (fifo_full_o),
    .fifo_empty_o      (fifo_empty_o),
    .dep_query_valid_o (dep_query_valid_o),
    .dep_blocked_i     (dep_blocked_i),
    .wb_req_o          (wb_req_o),
    .wb_id_o           (wb_id_o),
    .wb_done_i         (wb_done_i),
    .part_flush_o      (part_flush_o),
    .flush_id_o        (flush_id_o),
    .part_ack_i        (part_ack_i),
    .final_ack_o       (final_ack_o),
    .persisted_o       (persisted_o),
    .persisted_id_o    (persisted_id_o)
);

// File: tb/epoch_flush_seq_bench.sv
`timescale 1ns/1ps
module epoch_flush_seq_bench;
    localparam int NPART = 4;
    localparam int DEPTH = 4;
    localparam int ID_W  = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ep_start_i = 1'b0;
    logic [ID_W-1:0]  ep_start_id_i = '0;
    logic             ep_end_i = 1'b0;
    logic [NPART-1:0] early_req_i = '0;
    logic             fifo_full_o, fifo_empty_o;
    logic             dep_query_valid_o;
    logic [ID_W-1:0]  dep_query_id_o;
    logic             dep_blocked_i = 1'b0;
    logic             wb_req_o;
    logic [ID_W-1:0]  wb_id_o;
    logic             wb_done_i = 1'b0;
    logic [NPART-1:0] part_flush_o;
    logic [ID_W-1:0]  flush_id_o;
    logic [NPART-1:0] part_ack_i = '0;
    logic             final_ack_o, persisted_o;
    logic [ID_W-1:0]  persisted_id_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    epoch_flush_seq #(.NPART(NPART), .DEPTH(DEPTH), .ID_W(ID_W)) u_epoch_flush_seq (
        .clk(clk), .rst_n(rst_n),
        .ep_start_i(ep_start_i), .ep_start_id_i(ep_start_id_i), .ep_end_i(ep_end_i),
        .early_req_i(early_req_i), .fifo_full_o(fifo_full_o), .fifo_empty_o(fifo_empty_o),
        .dep_query_valid_o(dep_query_valid_o), .dep_query_id_o(dep_query_id_o),
        .dep_blocked_i(dep_blocked_i), .wb_req_o(wb_req_o), .wb_id_o(wb_id_o),
        .wb_done_i(wb_done_i), .part_flush_o(part_flush_o), .flush_id_o(flush_id_o),
        .part_ack_i(part_ack_i), .final_ack_o(final_ack_o), .persisted_o(persisted_o),
        .persisted_id_o(persisted_id_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic start_ep(input logic [ID_W-1:0] id);
        ep_start_i = 1'b1; ep_start_id_i = id;
        tick();
        ep_start_i = 1'b0;
    endtask

    task automatic end_ep();
        ep_end_i = 1'b1;
        tick();
        ep_end_i = 1'b0;
    endtask

    // Drives one epoch through writeback, flush, acks and retirement.
    task automatic flush_one(input logic [ID_W-1:0] exp, input int mode);
        logic [NPART-1:0] seq [6];
        int n;
        int waited = 0;
        while (!wb_req_o && waited < 60) begin tick(); waited++; end
        chk(wb_req_o == 1'b1, "R2 writeback requested", wb_req_o, 1);
        chk(wb_id_o == exp, "R2 writeback id in start order", wb_id_o, exp);
        for (int i = 0; i < 2; i++) begin
            tick();
            chk(wb_req_o && part_flush_o == '0, "R5 hold request, no flush", {wb_req_o, part_flush_o}, 5'h10);
        end
        wb_done_i = 1'b1;
        tick();
        wb_done_i = 1'b0;
        chk(part_flush_o == 4'hF && flush_id_o == exp, "R6 flush to all partitions",
            {part_flush_o, flush_id_o}, {4'hF, exp});
        tick();
        chk(part_flush_o == '0, "R6 flush single cycle", part_flush_o, 0);
        case (mode)
            0: begin seq[0]=4'b0001; seq[1]=4'b0010; seq[2]=4'b0100; seq[3]=4'b1000; n=4; end
            1: begin seq[0]=4'b1000; seq[1]=4'b0100; seq[2]=4'b0001; seq[3]=4'b0001;
                     seq[4]=4'b0100; seq[5]=4'b0010; n=6; end
            default: begin seq[0]=4'b1111; n=1; end
        endcase
        for (int i = 0; i < n; i++) begin
            part_ack_i = seq[i];
            tick();
            part_ack_i = '0;
            chk(final_ack_o == (i == n - 1), "R7 final ack after all partitions",
                final_ack_o, (i == n - 1));
        end
        chk(flush_id_o == exp, "R7 final ack names epoch", flush_id_o, exp);
        tick();
        chk(!final_ack_o && persisted_o && persisted_id_o == exp, "R8 persisted pulse",
            {final_ack_o, persisted_o, persisted_id_o}, {2'b01, exp});
        tick();
        chk(!persisted_o, "R8 persisted single cycle", persisted_o, 0);
    endtask

    task automatic t_reset();
        chk(fifo_empty_o && !fifo_full_o, "R1 queue empty after reset", {fifo_full_o, fifo_empty_o}, 1);
        chk(!dep_query_valid_o && !wb_req_o && part_flush_o == '0 && !final_ack_o && !persisted_o,
            "R1 outputs idle after reset",
            {dep_query_valid_o, wb_req_o, part_flush_o, final_ack_o, persisted_o}, 0);
    endtask

    task automatic t_proactive();
        start_ep(8'h21);
        end_ep();
        chk(!dep_query_valid_o, "R9 no query one cycle after close", dep_query_valid_o, 0);
        tick();
        chk(dep_query_valid_o && dep_query_id_o == 8'h21, "R9 query two cycles after close",
            {dep_query_valid_o, dep_query_id_o}, {1'b1, 8'h21});
        flush_one(8'h21, 0);
    endtask

    task automatic t_hold_open();
        start_ep(8'h30);
        for (int i = 0; i < 8; i++) begin
            tick();
            chk(!dep_query_valid_o && !wb_req_o, "R3 executing epoch untouched",
                {dep_query_valid_o, wb_req_o}, 0);
        end
        end_ep();
        flush_one(8'h30, 2);
    endtask

    task automatic t_order();
        start_ep(8'h41); end_ep();
        start_ep(8'h42); end_ep();
        start_ep(8'h43); end_ep();
        flush_one(8'h41, 1);
        flush_one(8'h42, 0);
        flush_one(8'h43, 2);
        chk(fifo_empty_o, "R2 queue drained after ordered run", fifo_empty_o, 1);
    endtask

    task automatic t_blocked();
        dep_blocked_i = 1'b1;
        start_ep(8'h55); end_ep();
        tick(); tick();
        for (int i = 0; i < 6; i++) begin
            chk(dep_query_valid_o && dep_query_id_o == 8'h55 && !wb_req_o,
                "R4 blocked head held in query", {dep_query_valid_o, wb_req_o, dep_query_id_o},
                {2'b10, 8'h55});
            tick();
        end
        dep_blocked_i = 1'b0;
        tick();
        chk(wb_req_o, "R4 resumes after block clears", wb_req_o, 1);
        flush_one(8'h55, 0);
    endtask

    task automatic t_early();
        start_ep(8'h66);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk(!wb_req_o && !dep_query_valid_o, "R10 no flush before early request",
                {wb_req_o, dep_query_valid_o}, 0);
        end
        early_req_i = 4'b0100;
        tick();
        early_req_i = '0;
        flush_one(8'h66, 1);
    endtask

    task automatic t_full();
        dep_blocked_i = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            start_ep(ID_W'(8'h70 + i));
            end_ep();
        end
        chk(fifo_full_o, "R11 full after DEPTH epochs", fifo_full_o, 1);
        start_ep(8'h7F);
        end_ep();
        chk(fifo_full_o, "R11 still full after dropped start", fifo_full_o, 1);
        dep_blocked_i = 1'b0;
        for (int i = 0; i < DEPTH; i++) flush_one(ID_W'(8'h70 + i), i % 3);
        chk(fifo_empty_o, "R11 empty after stored epochs", fifo_empty_o, 1);
        for (int i = 0; i < 6; i++) begin
            tick();
            chk(!dep_query_valid_o && !wb_req_o, "R11 dropped epoch never flushed",
                {dep_query_valid_o, wb_req_o}, 0);
        end
    endtask

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_proactive();
        t_hold_open();
        t_order();
        t_blocked();
        t_early();
        t_full();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule